// File: doc/BRIEF.md
# Trace Address-Range Filter Gate

This block decides, branch by branch, whether instruction-trace control-flow packets may be produced. Software programs a small set of address windows, each with a configuration code and inclusive low/high bounds. When at least one window is in filter mode and the platform supports filtering, every retired branch taken while tracing and context are both enabled re-evaluates whether its target lies inside any filter-mode window. The result is held as a filter-enable status bit. A packet-enable bit follows from trace enable, context enable and filter enable.

When a branch leaves the filtered region while packets were enabled, the block emits a one-cycle packet-generation-disable event. For direct unconditional and indirect branches the event carries the out-of-range target address. For other kinds the payload is suppressed. A combinational gate blocks the control-flow packet classes while packets are disabled. Synchronization, paging and timing classes pass whenever tracing is on.

Top module: `trace_range_gate`

## Requirements
- R1: While reset is asserted and in the first cycle after it, filter_en_o is 1, and pkt_en_o and pgd_valid_o are 0.
- R2: When no window has configuration code 1 (filter mode) or filt_supported_i is 0, filter_en_o is 1 in the following cycle.
- R3: While filtering is active (filt_supported_i is 1 and some window has code 1), filter_en_o changes only in the cycle after a branch (br_valid_i) seen with trace_en_i and ctx_en_i both 1.
- R4: After such a branch, filter_en_o is 1 exactly when br_target_i lies in at least one window whose code is 1; windows with codes 0, 2 or 3 are ignored.
- R5: Window bounds are inclusive: a target equal to the low bound or to the high bound is in the window.
- R6: pkt_en_o equals the registered AND of trace_en_i, ctx_en_i and the next value of filter_en_o.
- R7: pgd_valid_o pulses for one cycle after a branch that clears filter_en_o while pkt_en_o was 1.
- R8: On that pulse, pgd_ip_valid_o is 1 and pgd_ip_o holds the branch target when br_kind_i is 1 (direct unconditional) or 2 (indirect, including returns). For kind 0 (conditional) or 3 (far), pgd_ip_valid_o is 0 and pgd_ip_o is 0. Outside a pulse, both are 0.
- R9: pkt_grant_o for classes 0 (taken/not-taken) and 1 (target IP) equals pkt_req_i AND pkt_en_o.
- R10: pkt_grant_o for classes 2 (sync), 3 (paging) and 4 (timing) equals pkt_req_i AND trace_en_i, independent of the filter. Classes 5 to 7 are never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trace_en_i | input | 1 | Tracing enabled |
| ctx_en_i | input | 1 | Current context is traced |
| filt_supported_i | input | 1 | Strap: address filtering available |
| rng_cfg_i | input | NUM_RANGES*2 | Per-window configuration code, window n at bits [2n+1:2n] |
| rng_lo_i | input | NUM_RANGES*IP_W | Per-window inclusive low bound |
| rng_hi_i | input | NUM_RANGES*IP_W | Per-window inclusive high bound |
| br_valid_i | input | 1 | A branch retires this cycle |
| br_kind_i | input | 2 | Branch kind: 0 cond, 1 direct, 2 indirect, 3 far |
| br_target_i | input | IP_W | Branch target address |
| pkt_req_i | input | 1 | A packet asks to be emitted |
| pkt_class_i | input | 3 | Class of the requesting packet |
| filter_en_o | output | 1 | Filter-enable status |
| pkt_en_o | output | 1 | Packet-enable |
| pgd_valid_o | output | 1 | Packet-generation-disable event |
| pgd_ip_valid_o | output | 1 | Event carries an address |
| pgd_ip_o | output | IP_W | Address carried by the event |
| pkt_grant_o | output | 1 | Requested packet may be emitted |

## Verification
The assertions take it for granted that window configuration and the filtering strap hold steady around a branch. A code change in the same cycle as a branch is legal for the design, but it makes the stability property rely on the new setting. They also assume that all inputs are known after reset. The stimulus changes window bounds and codes only at the start of an epoch, and never on a cycle that carries a branch. It draws every input from a seeded generator, so no input is ever left unknown.

// File: rtl/trg_pkg.sv
// Shared encodings for the trace address-range filter gate.
// Assumes window configuration codes are two bits wide.
package trg_pkg;
    localparam int RCFG_W = 2;
    localparam logic [RCFG_W-1:0] RCFG_FILTER = 2'd1;

    typedef enum logic [1:0] {
        BK_COND     = 2'd0,
        BK_DIRECT   = 2'd1,
        BK_INDIRECT = 2'd2,
        BK_FAR      = 2'd3
    } br_kind_e;

    typedef enum logic [2:0] {
        PC_TNT  = 3'd0,
        PC_TIP  = 3'd1,
        PC_SYNC = 3'd2,
        PC_PAGE = 3'd3,
        PC_TIME = 3'd4
    } pkt_cls_e;
endpackage

// File: rtl/trg_range_match.sv
// Compares one address against every configured window.
// Reports whether any window is in filter mode and whether the address
// falls inside a filter-mode window (inclusive bounds). Purely combinational.
module trg_range_match #(
    parameter int NUM_RANGES = 2,
    parameter int IP_W       = 32
) (
    input  logic [NUM_RANGES*trg_pkg::RCFG_W-1:0] cfg_i,
    input  logic [NUM_RANGES*IP_W-1:0]            lo_i,
    input  logic [NUM_RANGES*IP_W-1:0]            hi_i,
    input  logic [IP_W-1:0]                       addr_i,
    output logic                                  any_filter_o,
    output logic                                  in_any_o
);
    import trg_pkg::*;

    logic [NUM_RANGES-1:0] is_filt;
    logic [NUM_RANGES-1:0] hit;

    for (genvar g = 0; g < NUM_RANGES; g++) begin : g_win
        logic [RCFG_W-1:0] code;
        logic [IP_W-1:0]   lo;
        logic [IP_W-1:0]   hi;
        // Slice the packed configuration for window g and test containment.
        always_comb begin
            code       = cfg_i[g*RCFG_W +: RCFG_W];
            lo         = lo_i[g*IP_W +: IP_W];
            hi         = hi_i[g*IP_W +: IP_W];
            is_filt[g] = (code == RCFG_FILTER);
            hit[g]     = is_filt[g] && (addr_i >= lo) && (addr_i <= hi);
        end
    end

    // Reduce per-window results.
    always_comb begin
        any_filter_o = |is_filt;
        in_any_o     = |hit;
    end
endmodule

// File: rtl/trg_filter_state.sv
// Holds filter-enable and packet-enable and produces the disable event.
// Assumes range match results are valid for the current branch target.
module trg_filter_state #(
    parameter int IP_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trace_en_i,
    input  logic            ctx_en_i,
    input  logic            filt_supported_i,
    input  logic            any_filter_i,
    input  logic            in_any_i,
    input  logic            br_valid_i,
    input  logic [1:0]      br_kind_i,
    input  logic [IP_W-1:0] br_target_i,
    output logic            filter_en_o,
    output logic            pkt_en_o,
    output logic            pgd_valid_o,
    output logic            pgd_ip_valid_o,
    output logic [IP_W-1:0] pgd_ip_o
);
    import trg_pkg::*;

    logic active, eval, filt_d, pkt_d, leave, carry;
    br_kind_e kind;

    // Next-state decisions for filter and packet enables.
    always_comb begin
        kind   = br_kind_e'(br_kind_i);
        active = filt_supported_i && any_filter_i;
        eval   = active && trace_en_i && ctx_en_i && br_valid_i;
        if (!active)   filt_d = 1'b1;
        else if (eval) filt_d = in_any_i;
        else           filt_d = filter_en_o;
        pkt_d  = trace_en_i && ctx_en_i && filt_d;
        leave  = eval && filter_en_o && !in_any_i && pkt_en_o;
        carry  = (kind == BK_DIRECT) || (kind == BK_INDIRECT);
    end

    // State and event registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filter_en_o    <= 1'b1;
            pkt_en_o       <= 1'b0;
            pgd_valid_o    <= 1'b0;
            pgd_ip_valid_o <= 1'b0;
            pgd_ip_o       <= '0;
        end else begin
            filter_en_o    <= filt_d;
            pkt_en_o       <= pkt_d;
            pgd_valid_o    <= leave;
            pgd_ip_valid_o <= leave && carry;
            pgd_ip_o       <= (leave && carry) ? br_target_i : '0;
        end
    end
endmodule

// File: rtl/trg_pkt_gate.sv
// Grants or blocks a packet request by class.
// Control-flow classes need packet-enable; sync, paging and timing need
// only trace enable; unknown classes are refused.
module trg_pkt_gate (
    input  logic       trace_en_i,
    input  logic       pkt_en_i,
    input  logic       req_i,
    input  logic [2:0] class_i,
    output logic       grant_o
);
    import trg_pkg::*;

    // Class decode.
    always_comb begin
        case (pkt_cls_e'(class_i))
            PC_TNT, PC_TIP:           grant_o = req_i && pkt_en_i;
            PC_SYNC, PC_PAGE, PC_TIME: grant_o = req_i && trace_en_i;
            default:                  grant_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/trace_range_gate.sv
// Top of the trace address-range filter gate.
// Wires the window matcher, the filter state and the packet class gate.
// Assumes all inputs are synchronous to clk.
module trace_range_gate #(
    parameter int NUM_RANGES = 2,
    parameter int IP_W       = 32
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  trace_en_i,
    input  logic                                  ctx_en_i,
    input  logic                                  filt_supported_i,
    input  logic [NUM_RANGES*trg_pkg::RCFG_W-1:0] rng_cfg_i,
    input  logic [NUM_RANGES*IP_W-1:0]            rng_lo_i,
    input  logic [NUM_RANGES*IP_W-1:0]            rng_hi_i,
    input  logic                                  br_valid_i,
    input  logic [1:0]                            br_kind_i,
    input  logic [IP_W-1:0]                       br_target_i,
    input  logic                                  pkt_req_i,
    input  logic [2:0]                            pkt_class_i,
    output logic                                  filter_en_o,
    output logic                                  pkt_en_o,
    output logic                                  pgd_valid_o,
    output logic                                  pgd_ip_valid_o,
    output logic [IP_W-1:0]                       pgd_ip_o,
    output logic                                  pkt_grant_o
);
    logic any_filter, in_any;

    trg_range_match #(.NUM_RANGES(NUM_RANGES), .IP_W(IP_W)) i_match (
        .cfg_i        (rng_cfg_i),
        .lo_i         (rng_lo_i),
        .hi_i         (rng_hi_i),
        .addr_i       (br_target_i),
        .any_filter_o (any_filter),
        .in_any_o     (in_any)
    );

    trg_filter_state #(.IP_W(IP_W)) i_state (
        .clk              (clk),
        .rst_n            (rst_n),
        .trace_en_i       (trace_en_i),
        .ctx_en_i         (ctx_en_i),
        .filt_supported_i (filt_supported_i),
        .any_filter_i     (any_filter),
        .in_any_i         (in_any),
        .br_valid_i       (br_valid_i),
        .br_kind_i        (br_kind_i),
        .br_target_i      (br_target_i),
        .filter_en_o      (filter_en_o),
        .pkt_en_o         (pkt_en_o),
        .pgd_valid_o      (pgd_valid_o),
        .pgd_ip_valid_o   (pgd_ip_valid_o),
        .pgd_ip_o         (pgd_ip_o)
    );

    trg_pkt_gate i_gate (
        .trace_en_i (trace_en_i),
        .pkt_en_i   (pkt_en_o),
        .req_i      (pkt_req_i),
        .class_i    (pkt_class_i),
        .grant_o    (pkt_grant_o)
    );
endmodule

// File: rtl/trg_checker.sv
// Temporal checks on the gate's ports; bound into every trace_range_gate.
module trg_checker #(
    parameter int NUM_RANGES = 2,
    parameter int IP_W       = 32
) (
    input logic                                  clk,
    input logic                                  rst_n,
    input logic                                  trace_en_i,
    input logic                                  ctx_en_i,
    input logic                                  filt_supported_i,
    input logic [NUM_RANGES*trg_pkg::RCFG_W-1:0] rng_cfg_i,
    input logic                                  br_valid_i,
    input logic                                  pkt_req_i,
    input logic [2:0]                            pkt_class_i,
    input logic                                  filter_en_o,
    input logic                                  pkt_en_o,
    input logic                                  pgd_valid_o,
    input logic                                  pgd_ip_valid_o,
    input logic [IP_W-1:0]                       pgd_ip_o,
    input logic                                  pkt_grant_o
);
    import trg_pkg::*;

    logic any_f;
    // Independent view of whether any window is in filter mode.
    always_comb begin
        any_f = 1'b0;
        for (int i = 0; i < NUM_RANGES; i++)
            if (rng_cfg_i[i*RCFG_W +: RCFG_W] == RCFG_FILTER) any_f = 1'b1;
    end

    // R2
    forced_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_f || !filt_supported_i) |=> filter_en_o);

    // R3
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (any_f && filt_supported_i && !(br_valid_i && trace_en_i && ctx_en_i))
        |=> $stable(filter_en_o));

    // R6
    pkt_needs_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_en_o |-> filter_en_o);

    // R7
    pgd_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pgd_valid_o |-> ($fell(filter_en_o) && $fell(pkt_en_o)));

    // R8
    pgd_ip_only_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pgd_ip_valid_o |-> (pgd_ip_o == '0));

    // R8
    pgd_ip_in_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pgd_ip_valid_o |-> pgd_valid_o);

    // R9
    cf_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_grant_o && pkt_class_i < 3'd2) |-> pkt_en_o);

    // R10
    other_cls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_req_i && trace_en_i && pkt_class_i >= 3'd2 && pkt_class_i <= 3'd4)
        |-> pkt_grant_o);
endmodule

bind trace_range_gate trg_checker #(.NUM_RANGES(NUM_RANGES), .IP_W(IP_W)) i_trg_checker (
    .clk              (clk),
    .rst_n            (rst_n),
    .trace_en_i       (trace_en_i),
    .ctx_en_i         (ctx_en_i),
    .filt_supported_i (filt_supported_i),
    .rng_cfg_i        (rng_cfg_i),
    .br_valid_i       (br_valid_i),
    .pkt_req_i        (pkt_req_i),
    .pkt_class_i      (pkt_class_i),
    .filter_en_o      (filter_en_o),
    .pkt_en_o         (pkt_en_o),
    .pgd_valid_o      (pgd_valid_o),
    .pgd_ip_valid_o   (pgd_ip_valid_o),
    .pgd_ip_o         (pgd_ip_o),
    .pkt_grant_o      (pkt_grant_o)
);

// File: tb/test_trace_range_gate.sv
module test_trace_range_gate;
    localparam int NR = 2;
    localparam int IW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trace_en = 0, ctx_en = 0, supp = 0, br_valid = 0, pkt_req = 0;
    logic [NR*2-1:0]  cfg = '0;
    logic [NR*IW-1:0] lo = '0, hi = '0;
    logic [1:0]  kind = 0;
    logic [IW-1:0] tgt = '0;
    logic [2:0]  cls = 0;
    logic filter_en, pkt_en, pgd_v, pgd_ipv, grant;
    logic [IW-1:0] pgd_ip;

    int n_chk = 0, n_bad = 0;
    bit m_filt = 1, m_pkt = 0;

    always #5 clk = ~clk;

    trace_range_gate #(.NUM_RANGES(NR), .IP_W(IW)) i_trace_range_gate (
        .clk(clk), .rst_n(rst_n), .trace_en_i(trace_en), .ctx_en_i(ctx_en),
        .filt_supported_i(supp), .rng_cfg_i(cfg), .rng_lo_i(lo), .rng_hi_i(hi),
        .br_valid_i(br_valid), .br_kind_i(kind), .br_target_i(tgt),
        .pkt_req_i(pkt_req), .pkt_class_i(cls), .filter_en_o(filter_en),
        .pkt_en_o(pkt_en), .pgd_valid_o(pgd_v), .pgd_ip_valid_o(pgd_ipv),
        .pgd_ip_o(pgd_ip), .pkt_grant_o(grant));

    task automatic chk(string req, logic [IW-1:0] act, logic [IW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit any_filt_f();
        for (int i = 0; i < NR; i++) if (cfg[i*2 +: 2] == 2'd1) return 1;
        return 0;
    endfunction

    function automatic bit inside_f(logic [IW-1:0] a);
        for (int i = 0; i < NR; i++)
            if (cfg[i*2 +: 2] == 2'd1 && a >= lo[i*IW +: IW] && a <= hi[i*IW +: IW]) return 1;
        return 0;
    endfunction

    function automatic bit grant_f();
        if (!pkt_req) return 0;
        if (cls <= 3'd1) return m_pkt;
        if (cls <= 3'd4) return trace_en;
        return 0;
    endfunction

    // One clock: inputs already driven; check gate, then outputs after edge.
    task automatic step();
        bit active, nf, np, lv, cr;
        #1;
        chk(cls <= 3'd1 ? "R9 grant" : "R10 grant", {31'd0, grant}, {31'd0, grant_f()});
        active = supp && any_filt_f();
        if (!active) nf = 1;
        else if (trace_en && ctx_en && br_valid) nf = inside_f(tgt);
        else nf = m_filt;
        np = trace_en && ctx_en && nf;
        lv = active && trace_en && ctx_en && br_valid && m_filt && !nf && m_pkt;
        cr = (kind == 2'd1) || (kind == 2'd2);
        @(posedge clk); #1;
        m_filt = nf; m_pkt = np;
        chk("R2 R3 R4 filter", {31'd0, filter_en}, {31'd0, nf});
        chk("R6 pkt_en", {31'd0, pkt_en}, {31'd0, np});
        chk("R7 pgd", {31'd0, pgd_v}, {31'd0, lv});
        chk("R8 pgd_ipv", {31'd0, pgd_ipv}, {31'd0, lv && cr});
        chk("R8 pgd_ip", pgd_ip, (lv && cr) ? tgt : '0);
        @(negedge clk);
    endtask

    task automatic branch(logic [IW-1:0] t, logic [1:0] k);
        br_valid = 1; tgt = t; kind = k;
        step();
        br_valid = 0;
    endtask

    initial begin : watchdog
        #1500000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (2) @(negedge clk);
        // R1: state during reset
        chk("R1 filter", {31'd0, filter_en}, 32'd1);
        chk("R1 pkt", {31'd0, pkt_en}, 32'd0);
        chk("R1 pgd", {31'd0, pgd_v}, 32'd0);
        rst_n = 1;
        @(posedge clk); #1;
        chk("R1 filter after", {31'd0, filter_en}, 32'd1);
        @(negedge clk);

        // Directed: window 0 filter [100,120], window 1 code 2 covering all (ignored, R4)
        trace_en = 1; ctx_en = 1; supp = 1;
        cfg = {2'd2, 2'd1};
        lo = {32'd0, 32'd100}; hi = {32'd255, 32'd120};
        step();
        branch(32'd110, 2'd1);
        chk("R4 inside", {31'd0, filter_en}, 32'd1);
        branch(32'd100, 2'd0);
        chk("R5 low bound", {31'd0, filter_en}, 32'd1);
        branch(32'd120, 2'd0);
        chk("R5 high bound", {31'd0, filter_en}, 32'd1);
        branch(32'd121, 2'd1);
        chk("R8 direct carries target", pgd_ip, 32'd121);
        branch(32'd105, 2'd2);
        branch(32'd99, 2'd0);
        chk("R8 cond suppresses", {31'd0, pgd_ipv}, 32'd0);
        chk("R7 cond still pulses", {31'd0, pgd_v}, 32'd1);
        step();
        chk("R7 single pulse", {31'd0, pgd_v}, 32'd0);
        // R3: branch while context disabled leaves filter alone
        ctx_en = 0; branch(32'd110, 2'd1); ctx_en = 1;
        chk("R3 ctx off no change", {31'd0, filter_en}, 32'd0);
        // R10: timing class passes while filtered out
        pkt_req = 1; cls = 3'd4; step();
        cls = 3'd0; step(); pkt_req = 0;
        // R2: strap off forces on
        supp = 0; step();
        chk("R2 strap off", {31'd0, filter_en}, 32'd1);
        supp = 1; branch(32'd200, 2'd2);
        cfg = {2'd3, 2'd0}; step();
        chk("R2 no filter window", {31'd0, filter_en}, 32'd1);

        // Random epochs
        for (int e = 0; e < 40; e++) begin
            br_valid = 0;
            for (int i = 0; i < NR; i++) begin
                logic [IW-1:0] a, b;
                a = $urandom % 256; b = a + ($urandom % 64);
                cfg[i*2 +: 2] = ($urandom % 3 == 0) ? 2'($urandom) : 2'd1;
                lo[i*IW +: IW] = a; hi[i*IW +: IW] = b;
            end
            supp = ($urandom % 10) != 0;
            step();
            for (int s = 0; s < 60; s++) begin
                trace_en = ($urandom % 8) != 0;
                ctx_en   = ($urandom % 6) != 0;
                br_valid = $urandom % 2;
                kind     = 2'($urandom);
                tgt      = $urandom % 330;
                pkt_req  = $urandom % 2;
                cls      = 3'($urandom);
                step();
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule